// File: doc/BRIEF.md
# Multi-Mode Frequency Synthesizer Phase Core

This block is the digital core of a direct digital synthesizer. A wide phase accumulator advances on every system clock by an active frequency word. A three-bit operating mode decides how that word is produced. It can be a fixed tone, a choice between two tuning words made by a select pin, a stepped glide toward the selected word, or a linear sweep that adds a delta word at a programmed rate. In the binary phase keying mode the select pin instead picks one of two phase offsets. These offsets are added to the truncated phase.

The truncated phase word and a programmed amplitude value go to a downstream phase-to-amplitude stage. Configuration arrives through a small write port that addresses the tuning, delta, rate, offset and control registers. An active-low master reset clears all tuning words and the accumulator, selects the fixed-tone mode and sets the amplitude to midscale. The result is a 0 Hz output at 0 phase. The output frequency is the active word times the clock frequency divided by 2^48.

Top module: `dds_phase_ctrl`

## Requirements
- R1: While reset is asserted and afterwards with no writes, `phase_o` is 0. All tuning, delta, rate and offset registers and the accumulator are 0, and the mode is 000.
- R2: With a mode of 000 (fixed tone), the accumulator (48 bits) advances each clock by tuning word 1. `phase_o` is its top 14 bits, so a word of k·2^34 makes `phase_o` step by k modulo 2^14 per clock.
- R3: In mode 001 (two-word keying), the active word is tuning word 1 while `sel_i` is 0 and tuning word 2 while `sel_i` is 1.
- R4: In mode 010 (ramped keying), on each rate tick the active word moves by the delta word toward the selected word (1 when `sel_i`=0, 2 when 1). It lands exactly on that word without overshoot and then holds.
- R5: In mode 011 (sweep), the delta word is added to the active word once every rate+1 clocks, wrapping modulo 2^48. Between ticks the word holds.
- R6: In mode 100 (phase keying), the frequency is tuning word 1. `phase_o` equals the accumulator top 14 bits plus offset A (`sel_i`=0) or offset B (`sel_i`=1), modulo 2^14. In every other mode the offset is 0.
- R7: Mode codes 101, 110 and 111 act as fixed tone, and `sel_i` has no effect in them.
- R8: Writes use the following addresses. 0 is tuning word 1, 1 is tuning word 2 and 2 is the delta word, all 48 bits. 3 is the rate, data bits [15:0]. 4 holds offset A in bits [13:0] and offset B in bits [27:14]. 5 is control, with the mode in bits [2:0] and the amplitude in bits [15:4]. Writes to addresses 6 and 7 change nothing.
- R9: `amp_o` shows the amplitude field. After reset it is midscale, 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 48 | Register write data |
| sel_i | input | 1 | Keying select pin |
| phase_o | output | 14 | Truncated phase word with offset |
| amp_o | output | 12 | Amplitude value for the output stage |

## Verification
All tuning and delta words are multiples of 2^34, so the per-clock difference of `phase_o` equals the active frequency exactly. This lets the bench read the frequency from the phase port alone. Fixed-tone steps are swept across small, midscale and wrapping values. In keying mode the select pin is toggled to tell word 1 from word 2, and in the codes 101 to 111 the same toggle must show no effect. Ramps are run up and down to expose overshoot or a wrong stop value, and a sweep crossing 2^48 checks the wrap and the rate+1 spacing. Phase offsets are checked against a frozen accumulator, so each offset pair gives an exact expected value.

// File: rtl/dds_pkg.sv
package dds_pkg;
  typedef enum logic [2:0] {
    MODE_TONE  = 3'd0,
    MODE_FSK   = 3'd1,
    MODE_RAMP  = 3'd2,
    MODE_CHIRP = 3'd3,
    MODE_BPSK  = 3'd4
  } mode_e;

  localparam logic [2:0] ADDR_FTW1  = 3'd0;
  localparam logic [2:0] ADDR_FTW2  = 3'd1;
  localparam logic [2:0] ADDR_DELTA = 3'd2;
  localparam logic [2:0] ADDR_RATE  = 3'd3;
  localparam logic [2:0] ADDR_OFFS  = 3'd4;
  localparam logic [2:0] ADDR_CTRL  = 3'd5;

  localparam int AMP_LSB = 4;

  // unused codes fall back to fixed tone
  function automatic mode_e eff_mode(logic [2:0] m);
    return (m > 3'd4) ? MODE_TONE : mode_e'(m);
  endfunction
endpackage

// File: rtl/dds_cfg_regs.sv
module dds_cfg_regs
  import dds_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int PH_W   = 14,
  parameter int AMP_W  = 12,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [ACC_W-1:0]  wr_data_i,
  output logic [ACC_W-1:0]  ftw1_o,
  output logic [ACC_W-1:0]  ftw2_o,
  output logic [ACC_W-1:0]  delta_o,
  output logic [RATE_W-1:0] rate_o,
  output logic [PH_W-1:0]   off_a_o,
  output logic [PH_W-1:0]   off_b_o,
  output logic [2:0]        mode_o,
  output logic [AMP_W-1:0]  amp_o
);
  localparam logic [AMP_W-1:0] AMP_MID = AMP_W'(1) << (AMP_W - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw1_o  <= '0;
      ftw2_o  <= '0;
      delta_o <= '0;
      rate_o  <= '0;
      off_a_o <= '0;
      off_b_o <= '0;
      mode_o  <= MODE_TONE;
      amp_o   <= AMP_MID;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_FTW1:  ftw1_o  <= wr_data_i;
        ADDR_FTW2:  ftw2_o  <= wr_data_i;
        ADDR_DELTA: delta_o <= wr_data_i;
        ADDR_RATE:  rate_o  <= wr_data_i[RATE_W-1:0];
        ADDR_OFFS: begin
          off_a_o <= wr_data_i[PH_W-1:0];
          off_b_o <= wr_data_i[PH_W +: PH_W];
        end
        ADDR_CTRL: begin
          mode_o <= wr_data_i[2:0];
          amp_o  <= wr_data_i[AMP_LSB +: AMP_W];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dds_rate_tick.sv
module dds_rate_tick #(
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = (cnt_q == '0);

  // one tick every rate_i+1 clocks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= rate_i;
    else             cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/dds_freq_sel.sv
module dds_freq_sel
  import dds_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int PH_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_e            mode_i,
  input  logic             sel_i,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] ftw1_i,
  input  logic [ACC_W-1:0] ftw2_i,
  input  logic [ACC_W-1:0] delta_i,
  input  logic [PH_W-1:0]  off_a_i,
  input  logic [PH_W-1:0]  off_b_i,
  output logic [ACC_W-1:0] freq_o,
  output logic [PH_W-1:0]  off_o
);
  logic [ACC_W-1:0] tgt, freq_d, up_gap, dn_gap, ramp_nxt;
  logic [PH_W-1:0]  off_d;

  assign tgt    = sel_i ? ftw2_i : ftw1_i;
  assign up_gap = tgt - freq_o;
  assign dn_gap = freq_o - tgt;

  // step toward target, clamp on arrival
  always_comb begin
    if (freq_o < tgt)
      ramp_nxt = (up_gap <= delta_i) ? tgt : freq_o + delta_i;
    else if (freq_o > tgt)
      ramp_nxt = (dn_gap <= delta_i) ? tgt : freq_o - delta_i;
    else
      ramp_nxt = freq_o;
  end

  always_comb begin
    freq_d = ftw1_i;
    off_d  = '0;
    unique case (mode_i)
      MODE_TONE:  freq_d = ftw1_i;
      MODE_FSK:   freq_d = tgt;
      MODE_RAMP:  freq_d = tick_i ? ramp_nxt : freq_o;
      MODE_CHIRP: freq_d = tick_i ? freq_o + delta_i : freq_o;
      MODE_BPSK: begin
        freq_d = ftw1_i;
        off_d  = sel_i ? off_b_i : off_a_i;
      end
      default: freq_d = ftw1_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_o <= '0;
      off_o  <= '0;
    end else begin
      freq_o <= freq_d;
      off_o  <= off_d;
    end
  end
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 48,
  parameter int PH_W  = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] freq_i,
  input  logic [PH_W-1:0]  off_i,
  output logic [PH_W-1:0]  phase_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      phase_o <= '0;
    end else begin
      acc_q   <= acc_q + freq_i;
      phase_o <= acc_q[ACC_W-1 -: PH_W] + off_i;
    end
  end
endmodule

// File: rtl/dds_phase_ctrl.sv
module dds_phase_ctrl
  import dds_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int PH_W   = 14,
  parameter int AMP_W  = 12,
  parameter int RATE_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [ACC_W-1:0] wr_data_i,
  input  logic             sel_i,
  output logic [PH_W-1:0]  phase_o,
  output logic [AMP_W-1:0] amp_o
);
  logic [ACC_W-1:0]  ftw1_q, ftw2_q, delta_q, freq_q;
  logic [RATE_W-1:0] rate_q;
  logic [PH_W-1:0]   off_a_q, off_b_q, off_q;
  logic [2:0]        mode_q;
  mode_e             mode_eff;
  logic              tick;

  assign mode_eff = eff_mode(mode_q);

  dds_cfg_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .RATE_W(RATE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ftw1_o(ftw1_q), .ftw2_o(ftw2_q), .delta_o(delta_q), .rate_o(rate_q),
    .off_a_o(off_a_q), .off_b_o(off_b_q), .mode_o(mode_q), .amp_o(amp_o)
  );

  dds_rate_tick #(.RATE_W(RATE_W)) u_tick (
    .clk_i, .rst_ni, .rate_i(rate_q), .tick_o(tick)
  );

  dds_freq_sel #(.ACC_W(ACC_W), .PH_W(PH_W)) u_sel (
    .clk_i, .rst_ni, .mode_i(mode_eff), .sel_i, .tick_i(tick),
    .ftw1_i(ftw1_q), .ftw2_i(ftw2_q), .delta_i(delta_q),
    .off_a_i(off_a_q), .off_b_i(off_b_q), .freq_o(freq_q), .off_o(off_q)
  );

  dds_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
    .clk_i, .rst_ni, .freq_i(freq_q), .off_i(off_q), .phase_o
  );
endmodule

// File: rtl/dds_phase_ctrl_chk.sv
module dds_phase_ctrl_chk
  import dds_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int PH_W  = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_addr_i,
  input logic             sel_i,
  input mode_e            mode_eff,
  input logic [2:0]       mode_q,
  input logic             tick,
  input logic [ACC_W-1:0] ftw1_q,
  input logic [ACC_W-1:0] ftw2_q,
  input logic [ACC_W-1:0] freq_q,
  input logic [PH_W-1:0]  off_q
);
  logic [ACC_W-1:0] tgt;
  assign tgt = sel_i ? ftw2_q : ftw1_q;

  assert_tone_tracks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == MODE_TONE) |=> (freq_q == $past(ftw1_q)));

  assert_fsk_pick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == MODE_FSK) |=> (freq_q == $past(tgt)));

  assert_ramp_no_overshoot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == MODE_RAMP && freq_q <= tgt) |=> (freq_q <= $past(tgt)));

  assert_chirp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff == MODE_CHIRP && !tick) |=> $stable(freq_q));

  assert_off_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_eff != MODE_BPSK) |=> (off_q == '0));

  assert_mode_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_CTRL) |=> $stable(mode_q));
endmodule

bind dds_phase_ctrl dds_phase_ctrl_chk #(.ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .sel_i, .mode_eff, .mode_q, .tick,
  .ftw1_q, .ftw2_q, .freq_q, .off_q
);

// File: tb/sim_dds_phase_ctrl.sv
module sim_dds_phase_ctrl;
  localparam int ACC_W = 48, PH_W = 14, AMP_W = 12, RATE_W = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_ni;
  logic             wr_en;
  logic [2:0]       wr_addr;
  logic [ACC_W-1:0] wr_data;
  logic             sel;
  logic [PH_W-1:0]  phase_o;
  logic [AMP_W-1:0] amp_o;

  int checks = 0, fails = 0;
  bit done = 0;
  int chv[16], cht[16], nch;

  dds_phase_ctrl #(.ACC_W(ACC_W), .PH_W(PH_W), .AMP_W(AMP_W), .RATE_W(RATE_W)) u0 (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .sel_i(sel), .phase_o, .amp_o
  );

  function automatic logic [ACC_W-1:0] fw(int k);
    return ACC_W'(k & 16'h3fff) << (ACC_W - PH_W);
  endfunction

  function automatic logic [ACC_W-1:0] ctrl(int mode, int amp);
    return (ACC_W'(amp) << 4) | ACC_W'(mode);
  endfunction

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [ACC_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_steps(input int k, input int n, input string req);
    logic [PH_W-1:0] prev, st;
    prev = phase_o;
    for (int i = 0; i < n; i++) begin
      cyc();
      st = phase_o - prev;
      prev = phase_o;
      chk(st == PH_W'(k), req, "phase step", st, k & 16'h3fff);
    end
  endtask

  // log each change of per-clock step: value and cycle index
  task automatic rec(input int ncyc);
    logic [PH_W-1:0] prev, st, last;
    prev = phase_o; cyc();
    last = phase_o - prev; prev = phase_o;
    nch = 0;
    for (int i = 0; i < ncyc; i++) begin
      cyc();
      st = phase_o - prev; prev = phase_o;
      if (st != last && nch < 16) begin
        chv[nch] = int'(st); cht[nch] = i; nch++;
      end
      last = st;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [PH_W-1:0] base;
    int offs_a[3], offs_b[3], steps[7];
    rst_ni = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sel = 1'b0;
    repeat (3) cyc();
    // R1 / R9: reset defaults
    chk(phase_o == 0, "R1", "phase in reset", phase_o, 0);
    chk(amp_o == 12'd2048, "R9", "amp in reset", amp_o, 2048);
    rst_ni = 1'b1;
    repeat (10) cyc();
    chk(phase_o == 0, "R1", "phase idle after reset", phase_o, 0);
    chk(amp_o == 12'd2048, "R9", "amp idle after reset", amp_o, 2048);

    // R2: fixed-tone sweep incl. wrap
    steps = '{1, 2, 3, 100, 8191, 8192, 16383};
    foreach (steps[i]) begin
      wr(3'd0, fw(steps[i]));
      repeat (6) cyc();
      check_steps(steps[i], 6, "R2");
    end

    // R9 / R8: control write
    wr(3'd5, ctrl(0, 12'h5a5));
    cyc();
    chk(amp_o == 12'h5a5, "R9", "amp after write", amp_o, 12'h5a5);

    // R8: unused addresses
    wr(3'd0, fw(9));
    repeat (6) cyc();
    wr(3'd6, '1);
    wr(3'd7, '1);
    repeat (6) cyc();
    check_steps(9, 4, "R8");
    chk(amp_o == 12'h5a5, "R8", "amp after unused write", amp_o, 12'h5a5);

    // R3: two-word keying
    wr(3'd0, fw(3));
    wr(3'd1, fw(7));
    wr(3'd5, ctrl(1, 12'h5a5));
    for (int r = 0; r < 3; r++) begin
      sel = 1'b0; repeat (6) cyc(); check_steps(3, 4, "R3");
      sel = 1'b1; repeat (6) cyc(); check_steps(7, 4, "R3");
    end

    // R7: reserved codes act as tone, sel ignored
    for (int m = 5; m < 8; m++) begin
      wr(3'd5, ctrl(m, 12'h5a5));
      sel = 1'b1; repeat (6) cyc(); check_steps(3, 3, "R7");
      sel = 1'b0; repeat (6) cyc(); check_steps(3, 3, "R7");
    end

    // R4: ramped keying up then down, rate 1 -> every 2 clocks
    wr(3'd5, ctrl(0, 12'h5a5));
    wr(3'd0, fw(2));
    wr(3'd1, fw(11));
    wr(3'd2, fw(4));
    wr(3'd3, 48'd1);
    sel = 1'b1;
    repeat (6) cyc();
    wr(3'd5, ctrl(2, 12'h5a5));
    rec(30);
    chk(nch == 3, "R4", "ramp up changes", nch, 3);
    chk(chv[0] == 6 && chv[1] == 10 && chv[2] == 11, "R4", "ramp up last value", chv[2], 11);
    chk(cht[1] - cht[0] == 2 && cht[2] - cht[1] == 2, "R4", "ramp up spacing", cht[1] - cht[0], 2);
    sel = 1'b0;
    rec(30);
    chk(nch == 3, "R4", "ramp down changes", nch, 3);
    chk(chv[0] == 7 && chv[1] == 3 && chv[2] == 2, "R4", "ramp down last value", chv[2], 2);
    chk(cht[2] - cht[1] == 2, "R4", "ramp down spacing", cht[2] - cht[1], 2);

    // R5: sweep with wrap, rate 2 -> every 3 clocks
    wr(3'd5, ctrl(0, 12'h5a5));
    wr(3'd0, fw(16381));
    wr(3'd2, fw(1));
    wr(3'd3, 48'd2);
    repeat (8) cyc();
    wr(3'd5, ctrl(3, 12'h5a5));
    rec(20);
    chk(nch >= 4, "R5", "sweep changes", nch, 4);
    chk(chv[0] == 16382 && chv[1] == 16383, "R5", "sweep values", chv[1], 16383);
    chk(chv[2] == 0 && chv[3] == 1, "R5", "sweep wrap", chv[2], 0);
    for (int i = 1; i < 4; i++)
      chk(cht[i] - cht[i-1] == 3, "R5", "sweep spacing", cht[i] - cht[i-1], 3);

    // R6: phase keying on frozen accumulator
    wr(3'd5, ctrl(0, 12'h5a5));
    wr(3'd0, '0);
    repeat (8) cyc();
    base = phase_o;
    offs_a = '{0, 16383, 16'h1234};
    offs_b = '{8191, 1, 16'h2abc};
    wr(3'd5, ctrl(4, 12'h5a5));
    foreach (offs_a[i]) begin
      wr(3'd4, (ACC_W'(offs_b[i]) << 14) | ACC_W'(offs_a[i]));
      sel = 1'b0; repeat (4) cyc();
      chk(phase_o == PH_W'(int'(base) + offs_a[i]), "R6", "offset A",
          phase_o, (int'(base) + offs_a[i]) & 16'h3fff);
      sel = 1'b1; repeat (4) cyc();
      chk(phase_o == PH_W'(int'(base) + offs_b[i]), "R6", "offset B",
          phase_o, (int'(base) + offs_b[i]) & 16'h3fff);
    end
    // R6: frequency stays word 1, offset removed outside the mode
    wr(3'd0, fw(5));
    repeat (6) cyc();
    check_steps(5, 4, "R6");
    wr(3'd5, ctrl(0, 12'h5a5));
    wr(3'd0, '0);
    repeat (8) cyc();
    base = phase_o;
    wr(3'd5, ctrl(4, 12'h5a5));
    repeat (4) cyc();
    wr(3'd5, ctrl(0, 12'h5a5));
    repeat (4) cyc();
    chk(phase_o == base, "R6", "offset cleared in tone", phase_o, base);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule